// File: doc/BRIEF.md
# Enhanced-Scan Pair Launcher

This block applies an arbitrary pair of state vectors to a piece of combinational logic and captures the logic's response to the second vector one clock period after it is launched. It is built as a chain of scan cells. Each cell is a flip-flop that either shifts serially or captures in parallel, and its output reaches the logic only through a hold latch. A controller receives one vector pair with the matching primary-input words on a request stream. It shifts the first vector in and releases the latches for one settle cycle. It then closes the latches and shifts the second vector in while the logic still sees the first. Releasing the latches again launches the second vector. The response is captured on the next clock edge, shifted out, and returned on a response stream.

Both streams are valid/ready. A request is taken on the edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so the requester holds its fields until that edge. The response stays valid with stable data until the consumer raises `rsp_ready`, and the block accepts nothing new until that handshake. The pins toward the logic under test and the status pins are plain, with no handshake.

Top module: `escan_top`

## Requirements
- R1: After reset `busy`, `scan_shift`, `rsp_valid`, `lut_state` and `lut_pi` are 0, while `hold` and `req_ready` are 1.
- R2: A request is accepted only on an edge with `req_valid` and `req_ready` both high. `req_ready` is 0 from the cycle after acceptance until the sequence ends, and request fields offered during that time have no effect on the result.
- R3: Each transaction has three shift phases (first load, second load, unload). Each phase is exactly N consecutive cycles with `scan_shift` high, and the phases are separated by non-shift cycles.
- R4: Bit N-1 of a vector is shifted in first. After N shifts, cell i holds bit i, and `lut_state[i]` shows bit i once the latches are open.
- R5: After the first load, `hold` is low for exactly one settle cycle, during which `lut_state` equals V1 and `lut_pi` equals the first primary-input word.
- R6: For all N cycles of the second load, `hold` is high, `lut_state` still equals V1 and `lut_pi` still equals the first primary-input word.
- R7: At the launch edge, `hold` falls and `lut_pi` switches to the second primary-input word. In that launch cycle `lut_state` equals V2.
- R8: The response on `lut_resp` is captured on the clock edge that ends the launch cycle, which is exactly one clock after launch. The next cycle keeps `hold` low with `lut_state` showing the captured value, and `hold` then rises.
- R9: While `hold` is high (1 = latches closed, 0 = transparent), `lut_state` does not change.
- R10: After unload, `rsp_valid` is 1 and `rsp_data[i]` equals `lut_resp[i]` as captured. Valid and data stay stable until `rsp_ready` is seen high on an edge, and the block is idle after that edge.
- R11: `busy` is 1 from the cycle after acceptance through the response handshake edge, and 0 otherwise.
- R12: V1 and V2 are independent. Equal, complementary, all-zero and all-one pairs each produce the response to V2 alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready, high when idle |
| req_v1 | input | N | State vector applied first |
| req_v2 | input | N | State vector launched second |
| req_pi1 | input | PW | Primary-input word shown with V1 |
| req_pi2 | input | PW | Primary-input word shown with V2 |
| rsp_valid | output | 1 | Response stream valid |
| rsp_ready | input | 1 | Response stream ready |
| rsp_data | output | N | Captured response of the logic |
| lut_state | output | N | Hold-latch outputs toward the logic under test |
| lut_pi | output | PW | Primary-input word toward the logic under test |
| lut_resp | input | N | Response of the logic under test |
| busy | output | 1 | A sequence is in progress |
| scan_shift | output | 1 | Test-control select: 1 = serial shift, 0 = functional |
| hold | output | 1 | Hold-latch control: 1 = keep, 0 = transparent |

## Verification
The bench follows every cycle of each sequence, so an off-by-one shift counter shows up as a phase of N-1 or N+1 shift cycles and as a response with rotated bits. A hold control released too early or too late makes the logic see a partly shifted second vector during the second load, or shows a stale vector in the launch cycle. A capture on the wrong edge returns the response to V1, or a value from the first unload shift. Equal, complementary and constant pairs expose a design that lets V1 leak into the result, and a stalled `rsp_ready` together with junk requests offered while busy expose a response that drifts or a request accepted out of turn.

// File: rtl/escan_pkg.sv
package escan_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD1,
    PH_SETTLE,
    PH_LOAD2,
    PH_LAUNCH,
    PH_POST,
    PH_UNLOAD,
    PH_DONE
  } phase_t;

  function automatic logic is_shift_phase(input phase_t p);
    return (p == PH_LOAD1) || (p == PH_LOAD2) || (p == PH_UNLOAD);
  endfunction

  function automatic logic is_open_phase(input phase_t p);
    return (p == PH_SETTLE) || (p == PH_LAUNCH) || (p == PH_POST);
  endfunction
endpackage

// File: rtl/escan_cell.sv
module escan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tc,
  input  logic si,
  input  logic d,
  input  logic hold,
  output logic so,
  output logic q
);
  logic ff_q;

  // scan flip-flop: shift when tc is high, functional capture otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ff_q <= 1'b0;
    else if (en) ff_q <= tc ? si : d;
  end

  // hold latch: transparent while hold is low
  always_latch begin
    if (!rst_n)     q = 1'b0;
    else if (!hold) q = ff_q;
  end

  assign so = ff_q;

  // R9: a closed latch keeps its value
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> $stable(q));
endmodule

// File: rtl/escan_chain.sv
module escan_chain #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         cap_en,
  input  logic         hold,
  input  logic         scan_in,
  input  logic [N-1:0] func_d,
  output logic         scan_out,
  output logic [N-1:0] held
);
  logic [N:0] link;
  logic       en;

  assign en      = shift_en | cap_en;
  assign link[0] = scan_in;

  for (genvar i = 0; i < N; i++) begin : g_cell
    escan_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .tc   (shift_en),
      .si   (link[i]),
      .d    (func_d[i]),
      .hold (hold),
      .so   (link[i+1]),
      .q    (held[i])
    );
  end

  assign scan_out = link[N];
endmodule

// File: rtl/escan_ctrl.sv
module escan_ctrl
  import escan_pkg::*;
#(
  parameter int N  = 8,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [N-1:0]  req_v1,
  input  logic [N-1:0]  req_v2,
  input  logic [PW-1:0] req_pi1,
  input  logic [PW-1:0] req_pi2,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [N-1:0]  rsp_data,
  output logic          busy,
  output logic          shift_en,
  output logic          cap_en,
  output logic          hold,
  output logic          scan_in,
  input  logic          scan_out,
  output logic [PW-1:0] pi_out
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  phase_t        ph, ph_nxt;
  logic [CW-1:0] cnt;
  logic          last;
  logic [N-1:0]  ld_q, v2_q, rsp_q;
  logic [PW-1:0] pi_q, pi2_q;
  logic          hold_q;

  assign last = (cnt == LAST);

  always_comb begin
    ph_nxt = ph;
    case (ph)
      PH_IDLE:   if (req_valid) ph_nxt = PH_LOAD1;
      PH_LOAD1:  if (last) ph_nxt = PH_SETTLE;
      PH_SETTLE: ph_nxt = PH_LOAD2;
      PH_LOAD2:  if (last) ph_nxt = PH_LAUNCH;
      PH_LAUNCH: ph_nxt = PH_POST;
      PH_POST:   ph_nxt = PH_UNLOAD;
      PH_UNLOAD: if (last) ph_nxt = PH_DONE;
      PH_DONE:   if (rsp_ready) ph_nxt = PH_IDLE;
      default:   ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      hold_q <= 1'b1;
    end else begin
      ph     <= ph_nxt;
      cnt    <= (ph_nxt != ph) ? '0 : cnt + 1'b1;
      hold_q <= !is_open_phase(ph_nxt);
    end
  end

  // serial source and primary-input word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q  <= '0;
      v2_q  <= '0;
      pi_q  <= '0;
      pi2_q <= '0;
    end else begin
      if (ph == PH_IDLE && req_valid) begin
        ld_q  <= req_v1;
        v2_q  <= req_v2;
        pi_q  <= req_pi1;
        pi2_q <= req_pi2;
      end else if (ph == PH_LOAD1 || ph == PH_LOAD2) begin
        ld_q <= {ld_q[N-2:0], 1'b0};
      end else if (ph == PH_SETTLE) begin
        ld_q <= v2_q;
      end
      if (ph == PH_LOAD2 && last) pi_q <= pi2_q;
    end
  end

  // unload collector, first bit out is the top cell
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rsp_q <= '0;
    else if (ph == PH_UNLOAD)  rsp_q <= {rsp_q[N-2:0], scan_out};
  end

  assign scan_in   = (ph == PH_LOAD1 || ph == PH_LOAD2) ? ld_q[N-1] : 1'b0;
  assign shift_en  = is_shift_phase(ph);
  assign cap_en    = (ph == PH_LAUNCH);
  assign hold      = hold_q;
  assign req_ready = (ph == PH_IDLE);
  assign busy      = (ph != PH_IDLE);
  assign rsp_valid = (ph == PH_DONE);
  assign rsp_data  = rsp_q;
  assign pi_out    = pi_q;

  // R3: a shift phase continues until its counter reaches N-1, then stops
  assert_shift_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !last) |=> shift_en);
  assert_shift_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && last) |=> !shift_en);
  // R8: capture happens only while the latches are open, one clock after load
  assert_capture_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (!hold && $past(ph) == PH_LOAD2));
  // R7: the primary-input word changes only on acceptance or at launch
  assert_pi_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pi_out) |-> (ph == PH_LAUNCH || ph == PH_LOAD1));
  // R10: a stalled response keeps its valid and data
  assert_rsp_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/escan_top.sv
module escan_top #(
  parameter int N  = 8,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [N-1:0]  req_v1,
  input  logic [N-1:0]  req_v2,
  input  logic [PW-1:0] req_pi1,
  input  logic [PW-1:0] req_pi2,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [N-1:0]  rsp_data,
  output logic [N-1:0]  lut_state,
  output logic [PW-1:0] lut_pi,
  input  logic [N-1:0]  lut_resp,
  output logic          busy,
  output logic          scan_shift,
  output logic          hold
);
  logic shift_en, cap_en, hold_c, sin, sout;

  escan_ctrl #(.N(N), .PW(PW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_v1   (req_v1),
    .req_v2   (req_v2),
    .req_pi1  (req_pi1),
    .req_pi2  (req_pi2),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_data (rsp_data),
    .busy     (busy),
    .shift_en (shift_en),
    .cap_en   (cap_en),
    .hold     (hold_c),
    .scan_in  (sin),
    .scan_out (sout),
    .pi_out   (lut_pi)
  );

  escan_chain #(.N(N)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_en),
    .cap_en  (cap_en),
    .hold    (hold_c),
    .scan_in (sin),
    .func_d  (lut_resp),
    .scan_out(sout),
    .held    (lut_state)
  );

  assign scan_shift = shift_en;
  assign hold       = hold_c;
endmodule

// File: tb/sim_escan_top.sv
module sim_escan_top;
  localparam int N  = 8;
  localparam int PW = 4;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [N-1:0]  req_v1 = '0, req_v2 = '0;
  logic [PW-1:0] req_pi1 = '0, req_pi2 = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [N-1:0]  rsp_data, lut_state, lut_resp;
  logic [PW-1:0] lut_pi;
  logic          busy, scan_shift, hold;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [N-1:0] prev_state = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  escan_top #(.N(N), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_v1(req_v1), .req_v2(req_v2), .req_pi1(req_pi1), .req_pi2(req_pi2),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .lut_state(lut_state), .lut_pi(lut_pi), .lut_resp(lut_resp),
    .busy(busy), .scan_shift(scan_shift), .hold(hold)
  );

  // model of the logic under test
  function automatic logic [N-1:0] lut_fn(input logic [N-1:0] s, input logic [PW-1:0] p);
    return s ^ {s[N-2:0], s[N-1]} ^ {p, ~p};
  endfunction

  always_comb lut_resp = lut_fn(lut_state, lut_pi);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_pair(input logic [N-1:0] v1, input logic [N-1:0] v2,
                          input logic [PW-1:0] p1, input logic [PW-1:0] p2,
                          input int stall, input bit junk);
    logic [N-1:0] exp_r;
    bit exp_sh, exp_hd;
    exp_r = lut_fn(v2, p2);
    @(negedge clk);
    req_valid = 1'b1; req_v1 = v1; req_v2 = v2; req_pi1 = p1; req_pi2 = p2;
    chk(req_ready == 1'b1, "R2 ready when idle", 32'(req_ready), 1);
    @(posedge clk);
    for (int c = 1; c <= 3*N + 4; c++) begin
      @(negedge clk);
      if (junk && c <= N) begin
        req_valid = 1'b1; req_v1 = ~v1; req_v2 = ~v2; req_pi1 = ~p1; req_pi2 = ~p2;
      end else begin
        req_valid = 1'b0;
      end
      chk(busy == 1'b1, "R11 busy in sequence", 32'(busy), 1);
      chk(req_ready == 1'b0, "R2 not ready while busy", 32'(req_ready), 0);
      exp_sh = (c <= N) || (c >= N+2 && c <= 2*N+1) || (c >= 2*N+4 && c <= 3*N+3);
      chk(scan_shift == exp_sh, "R3 shift cycle count", 32'(scan_shift), 32'(exp_sh));
      exp_hd = !(c == N+1 || c == 2*N+2 || c == 2*N+3);
      chk(hold == exp_hd, "R5 R8 hold timing", 32'(hold), 32'(exp_hd));
      if (c <= N)
        chk(lut_state == prev_state, "R9 latches closed in first load", 32'(lut_state), 32'(prev_state));
      else if (c == N+1) begin
        chk(lut_state == v1, "R4 R5 settle shows V1", 32'(lut_state), 32'(v1));
        chk(lut_pi == p1, "R5 settle pi", 32'(lut_pi), 32'(p1));
      end else if (c <= 2*N+1) begin
        chk(lut_state == v1, "R6 V1 kept during second load", 32'(lut_state), 32'(v1));
        chk(lut_pi == p1, "R6 pi kept during second load", 32'(lut_pi), 32'(p1));
      end else if (c == 2*N+2) begin
        chk(lut_state == v2, "R7 launch shows V2", 32'(lut_state), 32'(v2));
        chk(lut_pi == p2, "R7 launch pi", 32'(lut_pi), 32'(p2));
      end else if (c <= 3*N+3)
        chk(lut_state == exp_r, "R8 R9 captured value held", 32'(lut_state), 32'(exp_r));
      if (c == 3*N+4) begin
        chk(rsp_valid == 1'b1, "R10 response valid", 32'(rsp_valid), 1);
        chk(rsp_data == exp_r, "R10 R12 response data", 32'(rsp_data), 32'(exp_r));
      end else
        chk(rsp_valid == 1'b0, "R10 no early valid", 32'(rsp_valid), 0);
    end
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b1 && rsp_data == exp_r, "R10 stall keeps response", 32'(rsp_data), 32'(exp_r));
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(busy == 1'b0, "R11 idle after handshake", 32'(busy), 0);
    chk(rsp_valid == 1'b0, "R10 valid dropped", 32'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R2 ready again", 32'(req_ready), 1);
    prev_state = exp_r;
  endtask

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && scan_shift == 0 && rsp_valid == 0, "R1 reset flags", {busy, scan_shift, rsp_valid}, 0);
    chk(hold == 1 && req_ready == 1, "R1 reset hold/ready", {hold, req_ready}, 3);
    chk(lut_state == 0 && lut_pi == 0, "R1 reset outputs", {lut_state, lut_pi}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && hold == 1, "R1 after release", {busy, hold}, 1);
    // R12 directed pairs
    run_pair(8'h00, 8'hFF, 4'h0, 4'hF, 0, 0);
    run_pair(8'hFF, 8'h00, 4'hF, 4'h0, 2, 1);
    run_pair(8'hA5, 8'hA5, 4'h3, 4'h3, 0, 0);
    run_pair(8'h5A, 8'hA5, 4'h9, 4'h6, 1, 1);
    run_pair(8'h80, 8'h01, 4'h1, 4'h8, 3, 0);
    // random pairs
    for (int t = 0; t < 30; t++) begin
      run_pair(N'($urandom), N'($urandom), PW'($urandom), PW'($urandom),
               int'($urandom % 4), bit'($urandom % 2));
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule